// File: doc/BRIEF.md
# Five-Stage Pipelined RISC Core

This block is a 32-bit in-order processor core for a small instruction subset: register-register arithmetic and logic, word load, word store and branch-on-equal. Every instruction passes through the same five steps: fetch, decode with register read, execute, memory access and register write-back. Registers separate each step from the next, so a new instruction enters on every clock and one leaves on every clock. Unused steps do nothing for the instruction that passes through them. Because of this, the single register-file write port is only ever used in the fifth step.

The core has no forwarding paths and no interlocks. Software must allow for the timing these cause. A branch redirects fetch only after three more sequential instructions have been fetched, and all three of them execute. A loaded or computed register value can be read only by the fourth instruction after its producer or any later one. The core drives a word-aligned instruction address and reads the instruction word back in the same cycle. It drives the data port from a pipeline register, and the read data is expected back within the same cycle.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `imem_addr` = 0, `dmem_we` = 0 and no register-file write. Instructions in flight at reset are discarded.
- R2: When no branch is being taken, `imem_addr` rises by 4 on every clock. Instruction k after reset is fetched k cycles after `rst` falls.
- R3: Opcode bits [31:26] = 0 selects a register-register operation on rs [25:21] and rt [20:16], written to rd [15:11]. The function field [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than.
- R4: Opcode 0x23 loads the data word at rs + sign-extended imm [15:0] into rt. The result, like any register result, is seen by the fourth and later instructions after its producer.
- R5: Opcode 0x2B stores rt to address rs + sign-extended imm. `dmem_we` is high for one cycle, three cycles after the store was fetched, with `dmem_addr` and `dmem_wdata` valid in that same cycle.
- R6: Opcode 0x04 compares rs with rt. If they are equal, the fourth fetch after the branch comes from branch address + 4 + (sign-extended imm × 4); otherwise fetch goes on sequentially. The three instructions after the branch always execute.
- R7: Register 0 reads as zero, and writes to it are dropped.
- R8: An instruction decoded in the cycle in which its source register is being written gets the old value. This is the third instruction after the producer.
- R9: An unknown opcode, or opcode 0 with an unknown function code (the all-zero word is the no-op), writes neither a register nor memory.
- R10: A load followed directly by a register-register instruction leaves both results in the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | DATA_W | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | DATA_W | Byte address of the data access |
| dmem_wdata | output | DATA_W | Data to store |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | DATA_W | Data word at `dmem_addr`, same cycle |

## Verification
A wrong program counter or a wrong branch decision shows up at `imem_addr` within one cycle of the bad state. For a branch that means the cycle after its memory step. A corrupted register is hidden until a store reads it, so the program stores every result it computes. It places those stores at exactly the distances where the old value must still be seen (three instructions on) and where the new value must first be seen (four on). The sequence of store addresses, data words and cycle numbers then shows any error in decode, the ALU, the register file or the timing. That sequence includes a store that must not happen inside a taken branch's shadow and a repeated store that a wrongly taken branch would cause.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 5;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    load_sel;
    logic    mem_wr;
    logic    branch;
    logic    use_imm;
    logic    dst_rd;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  logic [5:0] op, fn;
  assign op = instr[31:26];
  assign fn = instr[5:0];

  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_REG: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_wr = 1'b1;
        unique case (fn)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_wr = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_wr   = 1'b1;
        ctrl.load_sel = 1'b1;
        ctrl.use_imm  = 1'b1;
      end
      OP_STORE: begin
        ctrl.mem_wr  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(DATA_W-1){1'b0}}, $signed(a) < $signed(b)};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  output logic [DATA_W-1:0]   imem_addr,
  input  logic [INSTR_W-1:0]  imem_rdata,
  output logic [DATA_W-1:0]   dmem_addr,
  output logic [DATA_W-1:0]   dmem_wdata,
  output logic                dmem_we,
  input  logic [DATA_W-1:0]   dmem_rdata
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);
  localparam int IMM_W = 16;

  // fetch
  logic [DATA_W-1:0] pc_q, pc_inc;
  // fetch -> decode
  logic               ifid_valid;
  logic [INSTR_W-1:0] ifid_instr;
  logic [DATA_W-1:0]  ifid_pc4;
  // decode
  ctrl_t              dec_ctrl, id_ctrl;
  logic [RIDX_W-1:0]  id_rs, id_rt, id_rd;
  logic [DATA_W-1:0]  id_a, id_b, id_imm;
  // decode -> execute
  ctrl_t              idex_ctrl;
  logic [DATA_W-1:0]  idex_a, idex_b, idex_imm, idex_pc4;
  logic [RIDX_W-1:0]  idex_dst;
  // execute
  logic [DATA_W-1:0]  ex_y, ex_opb, ex_tgt;
  logic               ex_zero;
  // execute -> memory
  ctrl_t              exmem_ctrl;
  logic [DATA_W-1:0]  exmem_y, exmem_sdata, exmem_tgt;
  logic               exmem_zero, exmem_we;
  logic [RIDX_W-1:0]  exmem_dst;
  logic               br_take;
  // memory -> write-back
  logic               memwb_we;
  logic [RIDX_W-1:0]  memwb_dst;
  logic [DATA_W-1:0]  memwb_data;

  // ---------------- fetch ----------------
  assign pc_inc    = pc_q + STEP;
  assign imem_addr = pc_q;

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (br_take) pc_q <= exmem_tgt;
    else              pc_q <= pc_inc;
  end

  always_ff @(posedge clk) begin
    ifid_valid <= !rst;
    ifid_instr <= imem_rdata;
    ifid_pc4   <= pc_inc;
  end

  // ---------------- decode ----------------
  pipe5_decode dec_i (.instr(ifid_instr), .ctrl(dec_ctrl));

  assign id_ctrl = ifid_valid ? dec_ctrl : '0;
  assign id_rs   = ifid_instr[25:21];
  assign id_rt   = ifid_instr[20:16];
  assign id_rd   = ifid_instr[15:11];
  assign id_imm  = {{(DATA_W-IMM_W){ifid_instr[IMM_W-1]}}, ifid_instr[IMM_W-1:0]};

  pipe5_regfile #(.DATA_W(DATA_W), .IDX_W(RIDX_W)) rf_i (
    .clk(clk), .we(memwb_we), .waddr(memwb_dst), .wdata(memwb_data),
    .raddr_a(id_rs), .raddr_b(id_rt), .rdata_a(id_a), .rdata_b(id_b)
  );

  always_ff @(posedge clk) begin
    idex_ctrl <= rst ? '0 : id_ctrl;
    idex_a    <= id_a;
    idex_b    <= id_b;
    idex_imm  <= id_imm;
    idex_pc4  <= ifid_pc4;
    idex_dst  <= dec_ctrl.dst_rd ? id_rd : id_rt;
  end

  // ---------------- execute ----------------
  assign ex_opb = idex_ctrl.use_imm ? idex_imm : idex_b;
  assign ex_tgt = idex_pc4 + {idex_imm[DATA_W-3:0], 2'b00};

  pipe5_alu #(.DATA_W(DATA_W)) alu_i (
    .op(idex_ctrl.alu_op), .a(idex_a), .b(ex_opb), .y(ex_y), .zero(ex_zero)
  );

  always_ff @(posedge clk) begin
    exmem_ctrl  <= rst ? '0 : idex_ctrl;
    exmem_we    <= !rst && idex_ctrl.mem_wr;
    exmem_y     <= ex_y;
    exmem_zero  <= ex_zero;
    exmem_sdata <= idex_b;
    exmem_tgt   <= ex_tgt;
    exmem_dst   <= idex_dst;
  end

  // ---------------- memory ----------------
  assign br_take    = exmem_ctrl.branch && exmem_zero;
  assign dmem_addr  = exmem_y;
  assign dmem_wdata = exmem_sdata;
  assign dmem_we    = exmem_we;

  always_ff @(posedge clk) begin
    memwb_we   <= !rst && exmem_ctrl.reg_wr;
    memwb_dst  <= exmem_dst;
    memwb_data <= exmem_ctrl.load_sel ? dmem_rdata : exmem_y;
  end
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] imem_addr,
  input logic              dmem_we,
  input logic              br_take,
  input logic [DATA_W-1:0] br_tgt,
  input logic              wb_we,
  input logic [4:0]        id_rs_addr,
  input logic [DATA_W-1:0] id_rs_data
);
  // R1: reset leaves fetch at zero and no write in flight
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (imem_addr == '0 && !dmem_we && !wb_we));

  // R2: sequential fetch steps by one word
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(br_take)) |-> imem_addr == $past(imem_addr) + DATA_W'(4));

  // R6: a taken branch redirects the very next fetch
  a_r6_branch_target: assert property (@(posedge clk) disable iff (rst)
    br_take |=> imem_addr == $past(br_tgt));

  // R7: register zero always reads zero
  a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
    (id_rs_addr == 5'd0) |-> id_rs_data == '0);
endmodule

bind pipe5_core pipe5_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .dmem_we(dmem_we),
  .br_take(br_take), .br_tgt(exmem_tgt), .wb_we(memwb_we),
  .id_rs_addr(id_rs), .id_rs_data(id_a)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSTORE = 20;

  function automatic logic [31:0] f_i(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] f_r(input logic [4:0] rd, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction
  function automatic logic [31:0] f_lw(input logic [4:0] rt, input logic [15:0] off);
    return f_i(6'h23, 5'd0, rt, off);
  endfunction
  function automatic logic [31:0] f_sw(input logic [4:0] rt, input logic [15:0] off);
    return f_i(6'h2B, 5'd0, rt, off);
  endfunction

  // program: the index is the fetch cycle when no branch is taken
  localparam logic [31:0] PROG [46] = '{
    f_lw(1, 16'h4), f_lw(2, 16'h8), f_lw(3, 16'hC), f_lw(4, 16'h4),       // 0-3
    32'h0, 32'h0, 32'h0,                                                  // 4-6
    f_r(5, 1, 2, 6'h20), f_r(6, 1, 2, 6'h22), f_r(7, 1, 3, 6'h24),        // 7-9
    f_r(8, 2, 3, 6'h25), f_r(9, 3, 1, 6'h2A), f_r(10, 1, 3, 6'h2A),       // 10-12
    f_r(0, 1, 1, 6'h20), f_i(6'h3F, 5'd1, 5'd5, 16'h1234),                // 13-14
    f_r(11, 1, 0, 6'h20),                                                 // 15
    f_sw(6, 16'h44), f_sw(7, 16'h48), f_sw(8, 16'h4C), f_sw(9, 16'h50),   // 16-19
    f_sw(10, 16'h54), f_sw(0, 16'h58), f_sw(5, 16'h5C),                   // 20-22
    f_lw(11, 16'h8),                                                      // 23
    f_sw(11, 16'h60), f_sw(11, 16'h64), f_sw(11, 16'h68), f_sw(11, 16'h6C), // 24-27
    f_lw(12, 16'hC), f_r(13, 1, 2, 6'h20), 32'h0, 32'h0, 32'h0,           // 28-32
    f_sw(12, 16'h70), f_sw(13, 16'h74),                                   // 33-34
    f_i(6'h04, 5'd1, 5'd4, 16'd4),                                        // 35 taken
    f_sw(1, 16'h78), f_sw(2, 16'h7C), f_sw(3, 16'h80), f_sw(1, 16'h84),   // 36-39
    f_i(6'h04, 5'd1, 5'd2, 16'd2),                                        // 40 not taken
    f_sw(2, 16'h88), f_sw(2, 16'h8C), f_sw(2, 16'h90), f_sw(4, 16'h94),   // 41-44
    f_i(6'h04, 5'd0, 5'd0, 16'hFFFF)                                      // 45 self loop
  };

  localparam logic [31:0] EXP_A [NSTORE] = '{
    32'h44, 32'h48, 32'h4C, 32'h50, 32'h54, 32'h58, 32'h5C, 32'h60, 32'h64, 32'h68,
    32'h6C, 32'h70, 32'h74, 32'h78, 32'h7C, 32'h80, 32'h88, 32'h8C, 32'h90, 32'h94
  };
  localparam logic [31:0] EXP_D [NSTORE] = '{
    32'd4, 32'd0, 32'hFFFFFFF3, 32'd1, 32'd0, 32'd0, 32'd10, 32'd7, 32'd7, 32'd7,
    32'd3, 32'hFFFFFFF0, 32'd10, 32'd7, 32'd3, 32'hFFFFFFF0, 32'd3, 32'd3, 32'd3, 32'd7
  };
  localparam string EXP_R [NSTORE] = '{
    "R3 sub", "R3 and", "R3 or", "R3 slt", "R3 slt", "R7 r0", "R9 unknown op",
    "R8 old value", "R8 old value", "R8 same-cycle", "R4 new value",
    "R10 load", "R10 reg op", "R6 slot", "R6 slot", "R6 slot",
    "R6 not taken", "R6 not taken", "R6 not taken", "R6 sequential"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata, imem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] log_a [32];
  logic [31:0] log_d [32];
  int          log_c [32];
  int          nlog = 0;
  int          cyc = 0;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe5_core #(.DATA_W(32)) dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      if (nlog < 32) begin
        log_a[nlog] = dmem_addr;
        log_d[nlog] = dmem_wdata;
        log_c[nlog] = cyc;
      end
      nlog = nlog + 1;
      dmem[dmem_addr[7:2]] = dmem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = (i < 46) ? PROG[i] : 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[1] = 32'd7;
    dmem[2] = 32'd3;
    dmem[3] = 32'hFFFFFFF0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", imem_addr, 32'h0);
    chk("R1 reset we", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    chk("R2 fetch c0", imem_addr, 32'h0);
    @(negedge clk);
    chk("R2 fetch c1", imem_addr, 32'h4);
    while (cyc != 39) @(negedge clk);
    chk("R6 taken target", imem_addr, 32'd160);
    while (cyc != 43) @(negedge clk);
    chk("R6 not taken sequential", imem_addr, 32'd176);
    while (cyc != 80) @(negedge clk);

    chk("R6 store count", nlog, NSTORE);
    for (int k = 0; k < NSTORE; k++) begin
      chk({EXP_R[k], " addr"}, log_a[k], EXP_A[k]);
      chk({EXP_R[k], " data"}, log_d[k], EXP_D[k]);
    end
    chk("R5 first store cycle", log_c[0], 32'd19);
    chk("R5 store cadence", log_c[6], 32'd25);

    // reset in the middle of the branch loop
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset pc", imem_addr, 32'h0);
    chk("R1 mid-run reset we", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R1 no store after reset", {31'd0, dmem_we}, 32'd0);
      chk("R2 restart fetch", imem_addr, 32'(4 * k));
      @(negedge clk);
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule